// File: doc/BRIEF.md
# I2C Master Byte Engine with Fixed-Parity Acknowledge

This block is the master side of a two-wire serial port. It drives the clock and shares one open-drain data line with a slave. Software sets up three registers: a control register, a divider register and a byte buffer that serves both directions. Each write to the buffer sends one byte, most significant bit first. A ninth acknowledge slot may follow the byte, and its level comes from a fixed-parity setting. One interrupt pulse marks the end of each byte.

The shift register is the same for both directions. Sending 0xFF leaves the data line released, so a slave can drive it. When receive is enabled, the levels sampled at each clock rise are collected, and the CPU reads them from the buffer after the interrupt. A start is issued before the first byte of a session. Clearing the mode bit ends the session: the byte in progress finishes, a stop is issued, receive is disabled and the engine goes idle with both lines released.

Register map, selected by `bus_addr`:
- Address 0 is control. Written bits: [0] receive enable, [1] I2C mode, [3:2] parity. Read bits: the same fields, plus [4] start seen, [5] stop seen and [6] busy.
- Address 1 is the byte buffer.
- Address 2 is the divider.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, control reads 0x00, the buffer reads 0x00, `irq` is low, and both `scl_oe` and `sda_oe` are low, so both lines are released.
- R2: A buffer write while idle with mode bit [1] set issues a start: data falls while the clock is high. The start flag (control bit 4) is set and the stop flag (bit 5) is cleared. A buffer write while idle with mode clear is ignored: no clock pulses, lines stay released, and the buffer still reads its old value.
- R3: Data bits appear MSB first. Data changes only while the clock is low. The time between clock rises within a byte is 4*(divider+1) system clocks.
- R4: Parity field [3:2] selects the acknowledge slot. 2'b11 gives a ninth clock with data released (high). 2'b10 gives a ninth clock with data driven low. 2'b00 and 2'b01 give no ninth clock, so 8 clocks per byte.
- R5: With receive enable [0] set, the buffer captures the line level at each data-bit clock rise. This is the wired-AND of the sent byte and the slave's byte, so sending 0xFF captures the slave byte. With receive enable clear, the buffer ends the byte holding the written value, whatever the slave drives.
- R6: `irq` is a single-cycle pulse after the last slot of each byte. While mode stays set, the clock is then held low. The next buffer write continues the session without a new start.
- R7: Buffer writes made while a byte is shifting are ignored.
- R8: Clearing the mode bit requests a stop. A byte in progress still completes all its slots. The stop is data rising while the clock is high. The stop flag is then set, the start flag and receive enable are cleared, and both lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 control, 1 buffer, 2 divider) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for the selected address |
| irq | output | 1 | End-of-byte interrupt pulse |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
The assertions assume three things about the inputs. `sda_in` is the wired-AND of the master's drive and a slave. The slave changes its drive only while the clock is low. Register writes come as single-cycle strobes. The bench slave updates its pull only on a clock fall it has observed, or while the engine is parked with the clock low, and releases the line for acknowledge slots. The assertions therefore never see the slave move data under a high clock.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_BIT = 3'd2,
                         S_HOLD = 3'd3, S_STOP = 3'd4;
  localparam logic [3:0] ACK_IDX = 4'd8;

  logic [2:0]       state;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [DIV_W-1:0] div, cnt;
  logic [7:0]       shreg;
  logic [1:0]       par;
  logic             rx_en, mode, start_f, stop_f, irq_r, scl_r, sda_r;

  wire run      = (state == S_START) || (state == S_BIT) || (state == S_STOP);
  wire tick     = run && (cnt == div);
  wire wr_ctrl  = bus_wr && (bus_addr == 2'd0);
  wire wr_buf   = bus_wr && (bus_addr == 2'd1);
  wire wr_div   = bus_wr && (bus_addr == 2'd2);
  wire has_ack  = par[1];
  wire last_bit = has_ack ? (bitn == ACK_IDX) : (bitn == 4'd7);
  wire out_bit  = (bitn == ACK_IDX) ? par[0] : shreg[7];

  assign irq    = irq_r;
  assign scl_oe = scl_r;
  assign sda_oe = sda_r;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {1'b0, run, stop_f, start_f, par, mode, rx_en};
      2'd1:    bus_rdata = shreg;
      2'd2:    bus_rdata = 8'(div);
      default: bus_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      ph      <= '0;
      bitn    <= '0;
      div     <= '0;
      cnt     <= '0;
      shreg   <= '0;
      par     <= '0;
      rx_en   <= 1'b0;
      mode    <= 1'b0;
      start_f <= 1'b0;
      stop_f  <= 1'b0;
      irq_r   <= 1'b0;
      scl_r   <= 1'b0;
      sda_r   <= 1'b0;
    end else begin
      irq_r <= 1'b0;
      cnt   <= (tick || !run) ? '0 : cnt + 1'b1;
      if (wr_div) div <= DIV_W'(bus_wdata);
      if (wr_ctrl) begin
        rx_en <= bus_wdata[0];
        mode  <= bus_wdata[1];
        par   <= bus_wdata[3:2];
      end
      case (state)
        S_IDLE: begin
          if (wr_buf && mode) begin
            shreg <= bus_wdata;
            state <= S_START;
            ph    <= '0;
          end
        end
        S_START: begin
          if (tick) begin
            ph <= ph + 1'b1;
            case (ph)
              2'd0: begin
                sda_r   <= 1'b1;
                start_f <= 1'b1;
                stop_f  <= 1'b0;
              end
              2'd2: scl_r <= 1'b1;
              2'd3: begin
                state <= S_BIT;
                bitn  <= '0;
              end
              default: ;
            endcase
          end
        end
        S_BIT: begin
          if (tick) begin
            ph <= ph + 1'b1;
            case (ph)
              2'd1: sda_r <= ~out_bit;
              2'd2: scl_r <= 1'b0;
              2'd3: begin
                scl_r <= 1'b1;
                if (bitn != ACK_IDX)
                  shreg <= {shreg[6:0], rx_en ? sda_in : shreg[7]};
                if (last_bit) begin
                  irq_r <= 1'b1;
                  state <= mode ? S_HOLD : S_STOP;
                end else begin
                  bitn <= bitn + 1'b1;
                end
              end
              default: ;
            endcase
          end
        end
        S_HOLD: begin
          if (wr_buf) begin
            shreg <= bus_wdata;
            state <= S_BIT;
            bitn  <= '0;
            ph    <= '0;
          end else if (!mode) begin
            state <= S_STOP;
            ph    <= '0;
          end
        end
        S_STOP: begin
          if (tick) begin
            ph <= ph + 1'b1;
            case (ph)
              2'd0: sda_r <= 1'b1;
              2'd1: scl_r <= 1'b0;
              2'd2: begin
                sda_r   <= 1'b0;
                stop_f  <= 1'b1;
                start_f <= 1'b0;
                rx_en   <= 1'b0;
              end
              default: state <= S_IDLE;
            endcase
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module i2c_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] state,
  input logic [3:0] bitn,
  input logic       start_f,
  input logic       stop_f,
  input logic       rx_en
);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_BIT = 3'd2,
                         S_HOLD = 3'd3, S_STOP = 3'd4;

  a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r6_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (state == S_HOLD || state == S_STOP));

  a_r3_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BIT && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));

  a_r3_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
    bitn <= 4'd8);

  a_r2_start_shape: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_f) |-> (state == S_START && sda_oe && !scl_oe));

  a_r8_stop_clears_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_f) |-> (!rx_en && !start_f && !scl_oe));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_byte_master i2c_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .state(state), .bitn(bitn), .start_f(start_f), .stop_f(stop_f), .rx_en(rx_en)
);

// File: tb/sim_i2c_byte_master.sv
`timescale 1ns/1ps
module sim_i2c_byte_master;
  logic       clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, pull = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  wire  [7:0] bus_rdata;
  wire        irq, scl_oe, sda_oe;
  wire        sda_in = ~(sda_oe | pull);

  i2c_byte_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, nbits = 0, last_rise = 0, period = 0, starts = 0, stops = 0;
  int cur_div = 0;
  logic [1:0]  cur_par = '0;
  bit          cur_rx = 0, slave_on = 0;
  logic [7:0]  sb = '0;
  logic [15:0] seen = '0;
  logic        scl_p = 1'b1, sda_p = 1'b1;

  always @(negedge clk) begin
    logic scl_l, sda_l;
    cyc++;
    scl_l = ~scl_oe;
    sda_l = sda_in;
    if (scl_l && !scl_p) begin
      seen = {seen[14:0], sda_l};
      if (nbits > 0) period = cyc - last_rise;
      last_rise = cyc;
      nbits++;
    end
    if (!scl_l && scl_p) pull = slave_on && (nbits < 8) && !sb[7 - nbits];
    if (scl_l && scl_p && sda_p && !sda_l) starts++;
    if (scl_l && scl_p && !sda_p && sda_l) stops++;
    scl_p = scl_l;
    sda_p = sda_l;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step();
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    step();
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic open_s(input int dv, input logic [1:0] p, input bit rx, input bit sl);
    cur_div = dv; cur_par = p; cur_rx = rx; slave_on = sl;
    starts = 0; stops = 0;
    wr(2'd2, 8'(dv));
    wr(2'd0, {4'b0, p, 1'b1, rx});
  endtask

  task automatic do_byte(input logic [7:0] tx, input logic [7:0] s, input bit first);
    logic [7:0] line, got, ctl;
    int expn;
    sb = s; nbits = 0; seen = '0;
    if (!first) pull = slave_on && !s[7];
    wr(2'd1, tx);
    while (!irq) @(negedge clk);
    step();
    expn = cur_par[1] ? 9 : 8;
    line = slave_on ? (tx & s) : tx;
    got  = cur_par[1] ? seen[8:1] : seen[7:0];
    chk(nbits == expn, "R4 slot count", nbits, expn);
    chk(got == line, "R3 bits MSB first", got, line);
    if (cur_par[1]) chk(seen[0] == cur_par[0], "R4 ack level", seen[0], cur_par[0]);
    chk(period == 4 * (cur_div + 1), "R3 bit period", period, 4 * (cur_div + 1));
    chk(scl_oe == 1'b1, "R6 clock held low", scl_oe, 1);
    rd(2'd1, got);
    chk(got == (cur_rx ? (tx & s) : tx), "R5 buffer", got, cur_rx ? (tx & s) : tx);
    if (first) begin
      rd(2'd0, ctl);
      chk(starts == 1, "R2 start event", starts, 1);
      chk(ctl[5:4] == 2'b01, "R2 flags", ctl[5:4], 1);
    end
  endtask

  task automatic close_s();
    logic [7:0] ctl;
    wr(2'd0, {4'b0, cur_par, 1'b0, cur_rx});
    do rd(2'd0, ctl); while (!ctl[5]);
    chk(ctl[0] == 1'b0, "R8 rx cleared", ctl[0], 0);
    chk(ctl[4] == 1'b0, "R8 start flag cleared", ctl[4], 0);
    repeat (8 * (cur_div + 1)) step();
    rd(2'd0, ctl);
    chk(ctl[6] == 1'b0, "R8 idle", ctl[6], 0);
    chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
    chk(stops == 1 && starts == 1, "R8 one stop", stops, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) step();
    rd(2'd0, d);
    chk(d == 8'h00, "R1 control reset", d, 0);
    rd(2'd1, d);
    chk(d == 8'h00, "R1 buffer reset", d, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1 outputs reset", {irq, scl_oe, sda_oe}, 0);
    rst_n = 1'b1;
    step();
    rd(2'd0, d);
    chk(d == 8'h00, "R1 control after release", d, 0);

    nbits = 0;
    wr(2'd1, 8'h3C);
    repeat (40) step();
    rd(2'd1, d);
    chk(nbits == 0 && !scl_oe && !sda_oe, "R2 ignored without mode", nbits, 0);
    chk(d == 8'h00, "R2 buffer untouched", d, 0);

    open_s(0, 2'b11, 1'b0, 1'b1);
    for (int i = 0; i < 256; i++) do_byte(8'(i), 8'(i * 73 + 29), i == 0);
    close_s();

    open_s(1, 2'b10, 1'b1, 1'b1);
    for (int i = 0; i < 256; i++) do_byte(8'hFF, 8'(i), i == 0);
    close_s();

    open_s(3, 2'b00, 1'b1, 1'b1);
    for (int i = 0; i < 32; i++) do_byte(8'(i * 11), 8'(i * 29 + 3), i == 0);
    close_s();

    open_s(0, 2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) do_byte(8'(i * 17 + 1), 8'h00, i == 0);
    close_s();

    open_s(0, 2'b10, 1'b1, 1'b0);
    sb = 8'h00; nbits = 0; seen = '0;
    wr(2'd1, 8'hA5);
    repeat (6) step();
    wr(2'd1, 8'h00);
    wr(2'd0, {4'b0, 2'b10, 1'b0, 1'b1});
    while (!irq) @(negedge clk);
    step();
    chk(nbits == 9, "R8 byte completes", nbits, 9);
    chk(seen[8:1] == 8'hA5, "R7 busy write ignored", seen[8:1], 8'hA5);
    rd(2'd1, d);
    chk(d == 8'hA5, "R7 buffer keeps byte", d, 8'hA5);
    do rd(2'd0, d); while (!d[5]);
    repeat (8) step();
    chk(stops == 1 && !scl_oe && !sda_oe, "R8 stop after byte", stops, 1);
    rd(2'd0, d);
    chk(d[1:0] == 2'b00, "R8 mode and rx clear", d[1:0], 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule